// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is the arithmetic and logic stage of a small single-accumulator controller. Each request carries a 4-bit operation code, an 8-bit operand (taken by the surrounding core from a register, from data memory or from an immediate byte) and the present accumulator value with its carry (C) and half-carry (AC) flags. The block computes the new accumulator and flags and holds them in an output register. The surrounding core writes that register back into its own state.

Requests enter on a valid/ready handshake and results leave on a second one. A request is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). When the consumer holds `out_ready` low while `out_valid` is high, the result stays frozen and no new request is taken. A request accepted at edge N is presented from edge N onward, so there is one cycle of latency. With `out_ready` tied high, one operation completes on every clock.

Operation codes: 0 add, 1 add with carry, 2 OR, 3 AND, 4 XOR, 5 increment, 6 decrement, 7 clear, 8 complement, 9 nibble swap, 10 rotate right, 11 rotate right through carry, 12 rotate left, 13 rotate left through carry, 14 decimal adjust, 15 move operand into the accumulator.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted request, `out_valid` is 0 and `acc_q`, `c_q` and `ac_q` are 0. Reset is asynchronous.
- R2: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An accepted request raises `out_valid` after the next edge. While `out_valid` is high and `out_ready` is low, the outputs hold and a presented request is not taken. `out_valid` falls after an edge where `out_ready` is high and nothing is accepted.
- R3: Op 0 gives acc_in + operand modulo 256. C becomes the carry out of bit 7 and AC the carry out of bit 3.
- R4: Op 1 gives acc_in + operand + c_in, with C and AC formed as in R3.
- R5: Ops 2, 3 and 4 give the bitwise OR, AND and XOR of acc_in and the operand. C and AC pass through unchanged.
- R6: Op 5 adds one to acc_in and op 6 subtracts one, both wrapping modulo 256. C and AC pass through unchanged.
- R7: Op 7 yields 0, op 8 yields the bitwise inverse of acc_in and op 15 yields the operand. C and AC pass through unchanged.
- R8: Op 9 exchanges bits 7:4 with bits 3:0. Op 10 rotates right with bit 0 entering bit 7, and op 12 rotates left with bit 7 entering bit 0. C and AC pass through unchanged.
- R9: Op 11 shifts right, with c_in entering bit 7 and bit 0 becoming C. Op 13 shifts left, with c_in entering bit 0 and bit 7 becoming C. AC passes through unchanged.
- R10: Op 14 first adds 6 when bits 3:0 exceed 9 or ac_in is 1. It then adds 0x60 when bits 7:4 of that intermediate exceed 9 or c_in is 1. AC passes through unchanged.
- R11: For op 14, C is 1 if c_in is 1 or if either adjust step carries out of bit 7; otherwise C is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| op | input | 4 | Operation code |
| operand | input | 8 | Second operand |
| acc_in | input | 8 | Current accumulator |
| c_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current half-carry flag |
| out_valid | output | 1 | Result register holds an unconsumed result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| acc_q | output | 8 | New accumulator |
| c_q | output | 1 | New carry flag |
| ac_q | output | 1 | New half-carry flag |

## Verification
The only state is the result register and its valid bit, so any fault in the datapath appears at `acc_q`, `c_q` or `ac_q` one edge after the request is accepted, and nowhere earlier. A flag that is wrongly updated or wrongly held shows in that same cycle, as long as the stimulus presents flag inputs that differ from the correct result. A fault in the hold logic shows during a stall: the output changes, or `in_ready` rises while the consumer is still blocked. The vectors pair each operation with carry-in values that expose both paths.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_OR   = 4'd2,
    OP_AND  = 4'd3,
    OP_XOR  = 4'd4,
    OP_INC  = 4'd5,
    OP_DEC  = 4'd6,
    OP_CLR  = 4'd7,
    OP_CPL  = 4'd8,
    OP_SWAP = 4'd9,
    OP_RR   = 4'd10,
    OP_RRC  = 4'd11,
    OP_RL   = 4'd12,
    OP_RLC  = 4'd13,
    OP_DADJ = 4'd14,
    OP_MOV  = 4'd15
  } alu_op_e;

endpackage

// File: rtl/acc_alu_add.sv
// Binary adder split at the half-word so the half-carry is a real carry.
module acc_alu_add #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          c_full,
  output logic          c_half
);
  localparam int NW = DW / 2;

  logic [NW-1:0]    lo;
  logic [DW-NW-1:0] hi;

  always_comb begin
    {c_half, lo} = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
    {c_full, hi} = {1'b0, a[DW-1:NW]} + {1'b0, b[DW-1:NW]} + {{(DW-NW){1'b0}}, c_half};
    sum = {hi, lo};
  end
endmodule

// File: rtl/acc_alu_dadj.sv
// Two-step decimal correction; the upper digit is tested after the lower fix.
module acc_alu_dadj #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic          c,
  input  logic          ac,
  output logic [DW-1:0] r,
  output logic          c_out
);
  localparam int NW = DW / 2;
  localparam logic [NW-1:0]      DIGIT_MAX = NW'(9);
  localparam logic [DW:0]        LO_FIX    = (DW+1)'(6);
  localparam logic [DW:0]        HI_FIX    = (DW+1)'(6) << NW;

  logic [DW-1:0] mid;
  logic          k_lo, k_hi;
  logic          fix_lo, fix_hi;

  always_comb begin
    fix_lo      = (a[NW-1:0] > DIGIT_MAX) || ac;
    {k_lo, mid} = {1'b0, a} + (fix_lo ? LO_FIX : '0);
    fix_hi      = (mid[DW-1:NW] > DIGIT_MAX) || c;
    {k_hi, r}   = {1'b0, mid} + (fix_hi ? HI_FIX : '0);
    c_out       = c | k_lo | k_hi;
  end
endmodule

// File: rtl/acc_alu_rot.sv
// Rotates, rotates through carry, and half swap.
module acc_alu_rot
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       mode,
  input  logic [DW-1:0] a,
  input  logic          c,
  output logic [DW-1:0] r,
  output logic          c_out
);
  localparam int NW = DW / 2;

  logic [DW-1:0] swapped;

  for (genvar i = 0; i < NW; i++) begin : g_swap
    assign swapped[i]      = a[i+NW];
    assign swapped[i+NW]   = a[i];
  end

  always_comb begin
    r     = a;
    c_out = c;
    unique case (mode)
      OP_SWAP: r = swapped;
      OP_RR:   r = {a[0], a[DW-1:1]};
      OP_RL:   r = {a[DW-2:0], a[DW-1]};
      OP_RRC: begin
        r     = {c, a[DW-1:1]};
        c_out = a[0];
      end
      OP_RLC: begin
        r     = {a[DW-2:0], c};
        c_out = a[DW-1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    op,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] acc_in,
  input  logic          c_in,
  input  logic          ac_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] acc_q,
  output logic          c_q,
  output logic          ac_q
);
  localparam logic [DW-1:0] ONE = DW'(1);

  alu_op_e       op_e;
  logic          fire;
  logic [DW-1:0] add_sum, da_r, rot_r;
  logic          add_c, add_h, da_c, rot_c;
  logic [DW-1:0] nxt_acc;
  logic          nxt_c, nxt_ac;

  assign op_e     = alu_op_e'(op);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  acc_alu_add #(.DW(DW)) u_add (
    .a      (acc_in),
    .b      (operand),
    .cin    ((op_e == OP_ADDC) && c_in),
    .sum    (add_sum),
    .c_full (add_c),
    .c_half (add_h)
  );

  acc_alu_dadj #(.DW(DW)) u_dadj (
    .a     (acc_in),
    .c     (c_in),
    .ac    (ac_in),
    .r     (da_r),
    .c_out (da_c)
  );

  acc_alu_rot #(.DW(DW)) u_rot (
    .mode  (op_e),
    .a     (acc_in),
    .c     (c_in),
    .r     (rot_r),
    .c_out (rot_c)
  );

  always_comb begin
    nxt_acc = acc_in;
    nxt_c   = c_in;
    nxt_ac  = ac_in;
    unique case (op_e)
      OP_ADD, OP_ADDC: begin
        nxt_acc = add_sum;
        nxt_c   = add_c;
        nxt_ac  = add_h;
      end
      OP_OR:   nxt_acc = acc_in | operand;
      OP_AND:  nxt_acc = acc_in & operand;
      OP_XOR:  nxt_acc = acc_in ^ operand;
      OP_INC:  nxt_acc = acc_in + ONE;
      OP_DEC:  nxt_acc = acc_in - ONE;
      OP_CLR:  nxt_acc = '0;
      OP_CPL:  nxt_acc = ~acc_in;
      OP_MOV:  nxt_acc = operand;
      OP_SWAP, OP_RR, OP_RL, OP_RRC, OP_RLC: begin
        nxt_acc = rot_r;
        nxt_c   = rot_c;
      end
      OP_DADJ: begin
        nxt_acc = da_r;
        nxt_c   = da_c;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_q     <= '0;
      c_q       <= 1'b0;
      ac_q      <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      acc_q     <= nxt_acc;
      c_q       <= nxt_c;
      ac_q      <= nxt_ac;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [3:0]    op,
  input logic [DW-1:0] operand,
  input logic [DW-1:0] acc_in,
  input logic          c_in,
  input logic          ac_in,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] acc_q,
  input logic          c_q,
  input logic          ac_q
);
  logic take;
  assign take = in_valid && in_ready;

  a_r2_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(acc_q) && $stable(c_q) && $stable(ac_q)));

  a_r3_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == 4'd0) |=> ({c_q, acc_q} == ({1'b0, $past(acc_in)} + {1'b0, $past(operand)})));

  a_r5_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (op == 4'd2 || op == 4'd3 || op == 4'd4)) |=> (c_q == $past(c_in) && ac_q == $past(ac_in)));

  a_r8_rotate_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (op == 4'd9 || op == 4'd10 || op == 4'd12))
      |=> ($countones(acc_q) == $countones($past(acc_in)) && c_q == $past(c_in)));

  a_r11_dadj_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == 4'd14 && c_in) |=> c_q);
endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_acc_alu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op        (op),
  .operand   (operand),
  .acc_in    (acc_in),
  .c_in      (c_in),
  .ac_in     (ac_in),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .acc_q     (acc_q),
  .c_q       (c_q),
  .ac_q      (ac_q)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] op = '0;
  logic [7:0] operand = '0;
  logic [7:0] acc_in = '0;
  logic       c_in = 1'b0;
  logic       ac_in = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] acc_q;
  logic       c_q, ac_q;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  acc_alu i_acc_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .operand(operand), .acc_in(acc_in), .c_in(c_in), .ac_in(ac_in),
    .out_valid(out_valid), .out_ready(out_ready),
    .acc_q(acc_q), .c_q(c_q), .ac_q(ac_q)
  );

  // row: op | operand | acc | c | ac | exp acc | exp c | exp ac | requirement
  localparam int NV = 25;
  localparam logic [35:0] VEC [NV] = '{
    {4'd0,  8'h28, 8'h3A, 1'b0, 1'b0, 8'h62, 1'b0, 1'b1, 4'd3},  // R3 half carry
    {4'd0,  8'h20, 8'hF0, 1'b0, 1'b1, 8'h10, 1'b1, 1'b0, 4'd3},  // R3 full carry
    {4'd1,  8'h00, 8'h0F, 1'b1, 1'b0, 8'h10, 1'b0, 1'b1, 4'd4},  // R4
    {4'd1,  8'h34, 8'h12, 1'b0, 1'b1, 8'h46, 1'b0, 1'b0, 4'd4},  // R4
    {4'd1,  8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 4'd4},  // R4 both carries
    {4'd2,  8'h0C, 8'hF0, 1'b1, 1'b1, 8'hFC, 1'b1, 1'b1, 4'd5},  // R5 OR
    {4'd3,  8'h3C, 8'hF0, 1'b0, 1'b1, 8'h30, 1'b0, 1'b1, 4'd5},  // R5 AND
    {4'd4,  8'h0F, 8'hFF, 1'b1, 1'b0, 8'hF0, 1'b1, 1'b0, 4'd5},  // R5 XOR
    {4'd5,  8'h00, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'd6},  // R6 wrap up
    {4'd6,  8'h00, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 4'd6},  // R6 wrap down
    {4'd7,  8'h00, 8'h5A, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 4'd7},  // R7 clear
    {4'd8,  8'h00, 8'h5A, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b1, 4'd7},  // R7 complement
    {4'd15, 8'h77, 8'h00, 1'b1, 1'b1, 8'h77, 1'b1, 1'b1, 4'd7},  // R7 move
    {4'd9,  8'h00, 8'h3C, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b1, 4'd8},  // R8 swap
    {4'd10, 8'h00, 8'h01, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0, 4'd8},  // R8 rotate right
    {4'd12, 8'h00, 8'h81, 1'b1, 1'b0, 8'h03, 1'b1, 1'b0, 4'd8},  // R8 rotate left
    {4'd11, 8'h00, 8'h01, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 4'd9},  // R9
    {4'd11, 8'h00, 8'h80, 1'b1, 1'b0, 8'hC0, 1'b0, 1'b0, 4'd9},  // R9
    {4'd13, 8'h00, 8'h80, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'd9},  // R9
    {4'd13, 8'h00, 8'h01, 1'b1, 1'b1, 8'h03, 1'b0, 1'b1, 4'd9},  // R9
    {4'd14, 8'h00, 8'h41, 1'b0, 1'b1, 8'h47, 1'b0, 1'b1, 4'd10}, // R10 low step by AC
    {4'd14, 8'h00, 8'h9B, 1'b0, 1'b0, 8'h01, 1'b1, 1'b0, 4'd10}, // R10 both steps
    {4'd14, 8'h00, 8'h12, 1'b0, 1'b0, 8'h12, 1'b0, 1'b0, 4'd10}, // R10 no step
    {4'd14, 8'h00, 8'h23, 1'b1, 1'b0, 8'h83, 1'b1, 1'b0, 4'd11}, // R11 C kept
    {4'd14, 8'h00, 8'hFA, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'd11}  // R11 carry from low step
  };

  task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [7:0] b, input logic [7:0] a,
                       input logic c, input logic h);
    in_valid = 1'b1; op = o; operand = b; acc_in = a; c_in = c; ac_in = h;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, "reset outputs", {5'd0, out_valid, acc_q, c_q, ac_q}, 16'd0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(1, "idle after reset", {5'd0, out_valid, acc_q, c_q, ac_q}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][35:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15], VEC[i][14]);
      @(posedge clk);
      @(negedge clk);
      check(int'(VEC[i][3:0]), $sformatf("vector %0d", i),
            {5'd0, out_valid, acc_q, c_q, ac_q}, {5'd0, 1'b1, VEC[i][13:4]});
    end

    // R2: drains when nothing new is offered
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(2, "valid drops", {15'd0, out_valid}, 16'd0);

    // R2: stall holds result and refuses a new request
    out_ready = 1'b0;
    drive(4'd0, 8'h01, 8'h01, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check(3, "add under stall", {5'd0, out_valid, acc_q, c_q, ac_q}, {5'd0, 1'b1, 8'h02, 1'b0, 1'b0});
    drive(4'd7, 8'h00, 8'hFF, 1'b1, 1'b1);
    check(2, "ready low in stall", {15'd0, in_ready}, 16'd0);
    @(posedge clk);
    @(negedge clk);
    check(2, "held in stall", {5'd0, out_valid, acc_q, c_q, ac_q}, {5'd0, 1'b1, 8'h02, 1'b0, 1'b0});
    out_ready = 1'b1;
    #1;
    check(2, "ready on drain", {15'd0, in_ready}, 16'd1);
    @(posedge clk);
    @(negedge clk);
    check(7, "clear after stall", {5'd0, out_valid, acc_q, c_q, ac_q}, {5'd0, 1'b1, 8'h00, 1'b1, 1'b1});

    // R1: asynchronous reset clears a held result
    drive(4'd15, 8'h5A, 8'h00, 1'b1, 1'b0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(1, "async reset", {5'd0, out_valid, acc_q, c_q, ac_q}, 16'd0);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule